// File: doc/BRIEF.md
# Banked Interrupt Aggregation Controller

This block gathers up to 160 interrupt sources laid out as five banks of 32 bits. Each bank owns an enable register and a status register. A source that is high in any clock cycle leaves a sticky status bit behind. Software acknowledges the event by writing a one to that status bit.

The first three banks form the function group and the last two form the error group. Each group drives its own interrupt line. A line is high when any status bit in its group is set and also enabled.

Each bank has a fixed number of populated bits: 32, 32, 24, 32 and 17. A source is numbered by its bit position, bank × 32 + bit, so numbering does not count sources densely. Two read-only helper words name the lowest pending enabled source in each group, so a handler can serve sources one at a time without scanning the banks itself.

Top module: `irq_bank_agg`

## Requirements
- R1: A source input that is high during a clock edge sets its status bit at that edge. The bit stays set until software clears it.
- R2: If a source is high in the same cycle that software writes a one to its status bit, the bit stays set.
- R3: `irq_fn_o` is high exactly when some bit in banks 0 to 2 is both set in status and enabled. `irq_err_o` follows the same rule for banks 3 and 4. The two lines are independent of each other.
- R4: A source is numbered bank × 32 + bit. The first source of bank 3 is therefore 96, and bit 0 of bank 4 is 128.
- R5: Bits 24 to 31 of bank 2 and bits 17 to 31 of bank 4 are not populated. They read as zero in both the enable and the status registers, and they never raise an output, even when their source input pulses.
- R6: Clearing an enable bit masks its source but keeps its pending status bit set.
- R7: Writing a one to a status bit clears it. Writing a zero to a status bit leaves it unchanged.
- R8: The helper word of a group reports the lowest pending enabled source, comparing bank first and then bit. Its valid bit equals that group's output line.
- R9: Addresses are byte offsets, and a write stores the full word.
  - Enable registers sit at 0x00, 0x04, 0x08, 0x0C and 0x10, for banks 0 to 4 in order.
  - Status registers sit at 0x14 to 0x24, in the same bank order.
  - The function-group helper sits at 0x28 and the error-group helper at 0x2C. A helper word carries the valid flag in bit 8 and the source number in bits 7:0.
  - Read data appears in the cycle after the read request.
  - Any other address reads as zero.
- R10: A synchronous active-low reset clears all enable and status registers. After reset both outputs are low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 160 | Source inputs, index = bank × 32 + bit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after the read |
| irq_fn_o | output | 1 | Function-group interrupt |
| irq_err_o | output | 1 | Error-group interrupt |

## Verification
A source event and a software acknowledge of the same status bit can land on the same clock edge. If the acknowledge wins, an event is silently lost.

The bench provokes this collision by holding source 7 high during the very cycle in which it writes a one to bit 7 of the bank 0 status register. It then reads that register back and expects bit 7 still set. It also expects the bank's other pending bit untouched.

The checker separately requires that any source high together with a clear of its own bit leaves that bit set on the next edge.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants and helpers for the banked interrupt aggregator.
// Assumes banks are at most 32 bits wide.
package irq_agg_pkg;

    localparam int BANK_W_MAX = 32;

    // Number of populated bits in each bank.
    function automatic int bank_pop(input int bank);
        case (bank)
            2:       return 24;
            4:       return 17;
            default: return BANK_W_MAX;
        endcase
    endfunction

    // Mask of populated bits for a bank.
    function automatic logic [BANK_W_MAX-1:0] bank_mask(input int bank);
        logic [BANK_W_MAX-1:0] m;
        m = '0;
        for (int i = 0; i < BANK_W_MAX; i++) begin
            if (i < bank_pop(bank)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_bank_cell.sv
// Module: one interrupt bank with an enable register and a sticky status register.
// Source inputs set status bits. A status write clears the bits written as one.
// A set on the same edge as a clear wins. Unpopulated bits are held at zero.
module irq_bank_cell #(
    parameter int BANK_W = 32,
    parameter logic [BANK_W-1:0] IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src,
    input  logic              en_we,
    input  logic              st_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] en_q,
    output logic [BANK_W-1:0] st_q,
    output logic [BANK_W-1:0] act
);

    logic [BANK_W-1:0] clr_vec;

    // Bits being acknowledged in this cycle.
    always_comb clr_vec = st_we ? wdata : '0;

    // Enable register: takes the full write, limited to populated bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wdata & IMPL;
    end

    // Status register: sticky set from sources, write-one-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= ((st_q & ~clr_vec) | src) & IMPL;
    end

    // Active bits: pending and enabled.
    always_comb act = st_q & en_q;

endmodule

// File: rtl/irq_lowest_pick.sv
// Module: finds the lowest set bit of a group's active vector and reports
// its source number, which is BASE plus the bit index. Purely combinational.
module irq_lowest_pick #(
    parameter int WIDTH = 96,
    parameter int BASE  = 0,
    parameter int NUM_W = 8
) (
    input  logic [WIDTH-1:0] act,
    output logic             vld,
    output logic [NUM_W-1:0] num
);

    // Scan downward so that the lowest set bit is the last one assigned.
    always_comb begin
        vld = 1'b0;
        num = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (act[i]) begin
                vld = 1'b1;
                num = NUM_W'(BASE + i);
            end
        end
    end

endmodule

// File: rtl/irq_reg_port.sv
// Module: register access port.
// Decodes word-aligned byte addresses into per-bank write strobes and
// registers the read data. The word layout is: enables, then statuses,
// then the function helper and the error helper. Unaligned or unknown
// addresses read as zero and write nothing.
module irq_reg_port #(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 6,
    parameter int NUM_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_BANKS*BANK_W-1:0] en_flat,
    input  logic [NUM_BANKS*BANK_W-1:0] st_flat,
    input  logic                        fn_vld,
    input  logic [NUM_W-1:0]            fn_num,
    input  logic                        err_vld,
    input  logic [NUM_W-1:0]            err_num,
    output logic [NUM_BANKS-1:0]        en_we,
    output logic [NUM_BANKS-1:0]        st_we,
    output logic [BANK_W-1:0]           rdata
);

    localparam int IW       = ADDR_W - 2;
    localparam int FN_WORD  = 2 * NUM_BANKS;
    localparam int ERR_WORD = 2 * NUM_BANKS + 1;

    logic          aligned;
    logic [IW-1:0] widx;
    logic [BANK_W-1:0] rd_mux;

    // Word index and alignment of the request.
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        widx    = addr[ADDR_W-1:2];
    end

    // Per-bank write strobes.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            en_we[b] = wr_en && aligned && (widx == IW'(b));
            st_we[b] = wr_en && aligned && (widx == IW'(NUM_BANKS + b));
        end
    end

    // Read multiplexer over all words.
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (widx == IW'(b))
                    rd_mux = en_flat[b*BANK_W +: BANK_W];
                if (widx == IW'(NUM_BANKS + b))
                    rd_mux = st_flat[b*BANK_W +: BANK_W];
            end
            if (widx == IW'(FN_WORD))  rd_mux = BANK_W'({fn_vld, fn_num});
            if (widx == IW'(ERR_WORD)) rd_mux = BANK_W'({err_vld, err_num});
        end
    end

    // Registered read data, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

endmodule

// File: rtl/irq_bank_agg.sv
// Module: top level of the banked interrupt aggregator.
// It has five banks: three form the function group and two the error group.
// Each group ORs its active bits onto one output line and has a helper word
// that names the lowest pending enabled source.
// Assumes the source inputs are synchronous to clk.
module irq_bank_agg #(
    parameter int NUM_BANKS = 5,
    parameter int FN_BANKS  = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 6,
    parameter int NUM_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] src_i,
    input  logic                        wr_en_i,
    input  logic                        rd_en_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [BANK_W-1:0]           wdata_i,
    output logic [BANK_W-1:0]           rdata_o,
    output logic                        irq_fn_o,
    output logic                        irq_err_o
);

    localparam int ERR_BANKS = NUM_BANKS - FN_BANKS;
    localparam int FN_BITS   = FN_BANKS * BANK_W;
    localparam int ERR_BITS  = ERR_BANKS * BANK_W;
    localparam int ALL_BITS  = NUM_BANKS * BANK_W;

    logic [ALL_BITS-1:0]  en_flat;
    logic [ALL_BITS-1:0]  st_flat;
    logic [ALL_BITS-1:0]  act_flat;
    logic [NUM_BANKS-1:0] en_we;
    logic [NUM_BANKS-1:0] st_we;
    logic                 fn_vld;
    logic                 err_vld;
    logic [NUM_W-1:0]     fn_num;
    logic [NUM_W-1:0]     err_num;

    // One cell per bank, each with its own populated-bit mask.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irq_bank_cell #(
            .BANK_W (BANK_W),
            .IMPL   (BANK_W'(irq_agg_pkg::bank_mask(b)))
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (src_i[b*BANK_W +: BANK_W]),
            .en_we (en_we[b]),
            .st_we (st_we[b]),
            .wdata (wdata_i),
            .en_q  (en_flat[b*BANK_W +: BANK_W]),
            .st_q  (st_flat[b*BANK_W +: BANK_W]),
            .act   (act_flat[b*BANK_W +: BANK_W])
        );
    end

    // Lowest pending enabled source of the function group.
    irq_lowest_pick #(.WIDTH(FN_BITS), .BASE(0), .NUM_W(NUM_W)) u_fn_pick (
        .act (act_flat[FN_BITS-1:0]),
        .vld (fn_vld),
        .num (fn_num)
    );

    // Lowest pending enabled source of the error group.
    irq_lowest_pick #(.WIDTH(ERR_BITS), .BASE(FN_BITS), .NUM_W(NUM_W)) u_err_pick (
        .act (act_flat[ALL_BITS-1:FN_BITS]),
        .vld (err_vld),
        .num (err_num)
    );

    // Register access port.
    irq_reg_port #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .ADDR_W    (ADDR_W),
        .NUM_W     (NUM_W)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .rd_en   (rd_en_i),
        .addr    (addr_i),
        .en_flat (en_flat),
        .st_flat (st_flat),
        .fn_vld  (fn_vld),
        .fn_num  (fn_num),
        .err_vld (err_vld),
        .err_num (err_num),
        .en_we   (en_we),
        .st_we   (st_we),
        .rdata   (rdata_o)
    );

    // Group output lines.
    always_comb begin
        irq_fn_o  = |act_flat[FN_BITS-1:0];
        irq_err_o = |act_flat[ALL_BITS-1:FN_BITS];
    end

endmodule

// File: rtl/irq_agg_chk.sv
// Module: assertion checker for irq_bank_agg, attached by bind below.
// It decodes status clears from the port signals on its own.
module irq_agg_chk #(
    parameter int NUM_BANKS = 5,
    parameter int FN_BANKS  = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_BANKS*BANK_W-1:0] src_i,
    input logic                        wr_en_i,
    input logic [ADDR_W-1:0]           addr_i,
    input logic [BANK_W-1:0]           wdata_i,
    input logic [NUM_BANKS*BANK_W-1:0] en_flat,
    input logic [NUM_BANKS*BANK_W-1:0] st_flat,
    input logic                        irq_fn_o,
    input logic                        irq_err_o,
    input logic                        fn_vld
);

    localparam int IW      = ADDR_W - 2;
    localparam int FN_BITS = FN_BANKS * BANK_W;
    localparam int ALL     = NUM_BANKS * BANK_W;

    logic [ALL-1:0] impl;
    logic [ALL-1:0] clr_vec;
    logic           armed;

    // Populated-bit mask and the clear vector of this cycle.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            impl[b*BANK_W +: BANK_W] = BANK_W'(irq_agg_pkg::bank_mask(b));
            clr_vec[b*BANK_W +: BANK_W] =
                (wr_en_i && addr_i[1:0] == 2'b00 &&
                 addr_i[ADDR_W-1:2] == IW'(NUM_BANKS + b)) ? wdata_i : '0;
        end
    end

    // Set after the first clock out of reset, so $past reads only post-reset cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_SRC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((st_flat & $past(src_i & impl)) == $past(src_i & impl))); // R1
    AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((st_flat & $past(src_i & clr_vec & impl)) == $past(src_i & clr_vec & impl))); // R2
    AST_FN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fn_o |-> (|en_flat[FN_BITS-1:0])); // R3
    AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err_o |-> (|en_flat[ALL-1:FN_BITS])); // R3
    AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_flat | en_flat) & ~impl) == '0); // R5
    AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (($past(st_flat) & ~$past(clr_vec) & ~st_flat) == '0)); // R6
    AST_HELPER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fn_vld == irq_fn_o); // R8

endmodule

bind irq_bank_agg irq_agg_chk #(
    .NUM_BANKS (NUM_BANKS),
    .FN_BANKS  (FN_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .en_flat   (en_flat),
    .st_flat   (st_flat),
    .irq_fn_o  (irq_fn_o),
    .irq_err_o (irq_err_o),
    .fn_vld    (fn_vld)
);

// File: tb/tb_irq_bank_agg.sv
// Testbench: a scoreboard for irq_bank_agg.
// The do_read task queues expected read data. A monitor compares each
// queued value with rdata_o in the cycle the data arrives.
module tb_irq_bank_agg;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [159:0] src_i = '0;
    logic         wr_en_i = 1'b0;
    logic         rd_en_i = 1'b0;
    logic [5:0]   addr_i = '0;
    logic [31:0]  wdata_i = '0;
    logic [31:0]  rdata_o;
    logic         irq_fn_o;
    logic         irq_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    irq_bank_agg dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_fn_o(irq_fn_o), .irq_err_o(irq_err_o)
    );

    always #5 clk = ~clk;

    // Marks the cycle in which read data is due.
    always @(posedge clk) rd_d <= rd_en_i;

    // Monitor: pops the expected value and compares it once data is due.
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata_o !== e) begin
                errors++;
                $display("FAIL %s: rdata actual=%h expected=%h", t, rdata_o, e);
            end
        end
    end

    task automatic do_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic pulse(input logic [159:0] v);
        @(negedge clk);
        src_i = v;
        @(negedge clk);
        src_i = '0;
    endtask

    task automatic chk_lines(input logic efn, input logic eerr, input string t);
        checks++;
        if (irq_fn_o !== efn || irq_err_o !== eerr) begin
            errors++;
            $display("FAIL %s: fn/err actual=%b%b expected=%b%b", t,
                     irq_fn_o, irq_err_o, efn, eerr);
        end
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [159:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk_lines(1'b0, 1'b0, "R10 outputs after reset");
        for (int i = 0; i < 12; i++) do_read(6'(i * 4), 32'h0, "R10 register after reset");
        // R9: register map, full-word enable write; R5: unpopulated enable bits
        do_write(6'h00, 32'hFFFF_FFFF);
        do_read(6'h00, 32'hFFFF_FFFF, "R9 enable bank0");
        do_write(6'h08, 32'hFFFF_FFFF);
        do_read(6'h08, 32'h00FF_FFFF, "R5 enable bank2 top bits");
        do_write(6'h10, 32'hFFFF_FFFF);
        do_read(6'h10, 32'h0001_FFFF, "R5 enable bank4 top bits");
        do_read(6'h30, 32'h0, "R9 unknown address");
        // R1/R4: latch sources 5 and 35
        v = '0; v[5] = 1'b1; v[35] = 1'b1;
        pulse(v);
        chk_lines(1'b1, 1'b0, "R3 fn line from bank0");
        do_read(6'h14, 32'h0000_0020, "R1 status bank0");
        do_read(6'h18, 32'h0000_0008, "R1 status bank1");
        do_read(6'h28, 32'h0000_0105, "R8 fn helper source 5");
        // R5: unpopulated source 94 ignored
        v = '0; v[94] = 1'b1;
        pulse(v);
        do_read(6'h1C, 32'h0, "R5 status bank2 unpopulated");
        // R6: mask keeps pending status
        do_write(6'h00, 32'h0);
        chk_lines(1'b0, 1'b0, "R6 fn line masked");
        do_read(6'h14, 32'h0000_0020, "R6 status kept when masked");
        do_read(6'h28, 32'h0, "R8 fn helper empty");
        do_write(6'h04, 32'hFFFF_FFFF);
        chk_lines(1'b1, 1'b0, "R3 fn line from bank1");
        do_read(6'h28, 32'h0000_0123, "R4 fn helper source 35");
        // R7: write-one-to-clear, zero leaves unchanged
        do_write(6'h18, 32'h0000_0008);
        chk_lines(1'b0, 1'b0, "R7 fn line after clear");
        do_read(6'h18, 32'h0, "R7 status bank1 cleared");
        do_write(6'h14, 32'h0);
        do_read(6'h14, 32'h0000_0020, "R7 write zero keeps status");
        // Error group: sources 100 and 128
        do_write(6'h0C, 32'h0000_0010);
        v = '0; v[100] = 1'b1; v[128] = 1'b1;
        pulse(v);
        chk_lines(1'b0, 1'b1, "R3 err line only");
        do_read(6'h20, 32'h0000_0010, "R4 status bank3");
        do_read(6'h2C, 32'h0000_0164, "R8 err helper source 100");
        do_write(6'h20, 32'h0000_0010);
        do_read(6'h2C, 32'h0000_0180, "R4 err helper source 128");
        chk_lines(1'b0, 1'b1, "R3 err line bank4");
        do_write(6'h24, 32'h0000_0001);
        chk_lines(1'b0, 1'b0, "R3 err line cleared");
        do_read(6'h2C, 32'h0, "R8 err helper empty");
        // R2: set and clear of bit 7 on the same edge
        @(negedge clk);
        src_i[7] = 1'b1; wr_en_i = 1'b1; addr_i = 6'h14; wdata_i = 32'h0000_0080;
        @(negedge clk);
        src_i = '0; wr_en_i = 1'b0;
        do_read(6'h14, 32'h0000_00A0, "R2 set wins over clear");
        // R8: lowest bit first within a bank
        do_write(6'h00, 32'hFFFF_FFFF);
        chk_lines(1'b1, 1'b0, "R3 fn line re-enabled");
        do_read(6'h28, 32'h0000_0105, "R8 fn helper lowest of 5 and 7");
        do_write(6'h14, 32'h0000_00A0);
        chk_lines(1'b0, 1'b0, "R7 fn line after full clear");
        do_read(6'h14, 32'h0, "R7 status bank0 cleared");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule